// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block sits between a MAC's byte-wide transmit path and the two-bit transmit data pins of a reduced media-independent interface, running at 100 Mbps on the 50 MHz reference clock. Upstream logic offers frame bytes, including the frame check sequence, over a valid/ready handshake with an end-of-frame marker. The block puts seven preamble bytes and the start-of-frame delimiter in front of the frame on its own. It then shifts every byte onto the pins as four dibits, one per clock, with the lowest two bits first.

The transmit-enable output is high for exactly the dibits of a frame. Between frames the data pins carry an idle code, which is either the normal idle code or the low-power-idle code depending on a request input. If upstream fails to have a byte ready when one is due, the frame is cut short and a one-cycle underrun pulse is raised. All pin outputs come straight from flip-flops.

Top module: `rmii_tx_dibit_ser`

## Requirements
- R1: After reset, and while reset is held, `rmii_tx_en` is 0, `rmii_txd` is 00, `s_ready` is 0 and `underrun_pulse` is 0.
- R2: A frame starts with `s_valid` high while the line is idle and no low-power idle is requested. `rmii_tx_en` rises in the same cycle as the first preamble dibit. The first 32 dibits form seven bytes of 0x55 and then 0xD5, each byte sent least significant dibit first.
- R3: Payload bytes follow the delimiter with no gap. Each byte appears as four dibits, one per cycle: bits [1:0], then [3:2], then [5:4], then [7:6].
- R4: `rmii_tx_en` stays high with no gap for exactly 32 + 4*N cycles for a frame of N bytes. It is low in the first cycle after the final dibit.
- R5: `s_ready` is high only in a cycle that consumes a byte, once per payload byte. The first `s_ready` falls in the cycle that produces the last delimiter dibit, which is when 31 dibits are already on the pins.
- R6: While `rmii_tx_en` is low and `lpi_req` was low in the previous cycle, `rmii_txd` is 00.
- R7: While `rmii_tx_en` is low and `lpi_req` was high in the previous cycle, `rmii_txd` is 01.
- R8: Raising `lpi_req` during a frame does not alter the frame's dibits or length. The idle code 01 appears from the first cycle after `rmii_tx_en` falls.
- R9: If `s_valid` is low when a byte is due, the frame ends after the current byte's final dibit. This also applies to the first payload byte. `underrun_pulse` is high for exactly one cycle, the cycle of that final dibit.
- R10: While `lpi_req` is high and the line is idle, `s_valid` is ignored and `rmii_tx_en` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Byte offered by the MAC |
| s_data | input | 8 | Offered byte |
| s_last | input | 1 | Offered byte ends the frame |
| s_ready | output | 1 | Offered byte is consumed at this edge |
| lpi_req | input | 1 | Request low-power idle code between frames |
| rmii_tx_en | output | 1 | Transmit enable pin |
| rmii_txd | output | 2 | Transmit data dibit pin |
| underrun_pulse | output | 1 | One-cycle flag: frame aborted for lack of data |

## Verification
Two functions can coincide on one cycle: the end of a frame and a change of the idle code. The bench raises `lpi_req` while payload is still being shifted. It then checks that every frame dibit and the enable length are unchanged, and that the very first idle cycle already shows 01. The second collision is an underrun on the first payload byte load, in the same cycle as the last delimiter dibit. There the bench expects a 32-dibit frame and a pulse aligned with that last dibit.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

    localparam int BYTE_W          = 8;
    localparam int DIBIT_W         = 2;
    localparam int DIBITS_PER_BYTE = BYTE_W / DIBIT_W;
    localparam int IDX_W           = $clog2(DIBITS_PER_BYTE);

    localparam logic [BYTE_W-1:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [BYTE_W-1:0]  SFD_BYTE      = 8'hD5;
    localparam logic [DIBIT_W-1:0] IDLE_NORMAL   = 2'b00;
    localparam logic [DIBIT_W-1:0] IDLE_LPI      = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_PAYLOAD
    } seq_state_e;

    // Next dibit request from the sequencer to the pin stage
    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] byte_val;
        logic [IDX_W-1:0]  idx;
    } emit_t;

    function automatic logic [DIBIT_W-1:0] idle_code(input logic lpi);
        return lpi ? IDLE_LPI : IDLE_NORMAL;
    endfunction

endpackage

// File: rtl/rmii_tx_seq.sv
module rmii_tx_seq
    import rmii_tx_pkg::*;
#(
    parameter int PREAMBLE_LEN = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              lpi_req,
    input  logic              line_busy,
    output logic              in_ready,
    output emit_t             emit,
    output logic              underrun_det
);

    localparam int CNT_W = $clog2(PREAMBLE_LEN + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIBITS_PER_BYTE - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PREAMBLE_LEN - 1);
    localparam logic [CNT_W-1:0] PRE_DONE = CNT_W'(PREAMBLE_LEN);

    seq_state_e        state_q, state_d;
    logic [BYTE_W-1:0] cur_q, cur_d;
    logic              last_q, last_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [CNT_W-1:0]  pcnt_q, pcnt_d;

    always_comb begin
        state_d      = state_q;
        cur_d        = cur_q;
        last_d       = last_q;
        idx_d        = idx_q;
        pcnt_d       = pcnt_q;
        in_ready     = 1'b0;
        underrun_det = 1'b0;
        emit         = '{en: 1'b0, byte_val: cur_q, idx: idx_q};

        case (state_q)
            ST_IDLE: begin
                // at least one idle cycle after a frame, none while in LPI
                if (in_valid && !lpi_req && !line_busy) begin
                    emit    = '{en: 1'b1, byte_val: PREAMBLE_BYTE, idx: '0};
                    state_d = ST_PREAMBLE;
                    cur_d   = PREAMBLE_BYTE;
                    idx_d   = IDX_W'(1);
                    pcnt_d  = '0;
                    last_d  = 1'b0;
                end
            end
            default: begin
                emit.en = 1'b1;
                if (idx_q != LAST_IDX) begin
                    idx_d = idx_q + 1'b1;
                end else begin
                    idx_d = '0;
                    if (state_q == ST_PREAMBLE && pcnt_q < PRE_LAST) begin
                        pcnt_d = pcnt_q + 1'b1;
                        cur_d  = PREAMBLE_BYTE;
                    end else if (state_q == ST_PREAMBLE && pcnt_q == PRE_LAST) begin
                        pcnt_d = PRE_DONE;
                        cur_d  = SFD_BYTE;
                    end else if (state_q == ST_PAYLOAD && last_q) begin
                        state_d = ST_IDLE;
                    end else if (in_valid) begin
                        in_ready = 1'b1;
                        cur_d    = in_data;
                        last_d   = in_last;
                        state_d  = ST_PAYLOAD;
                    end else begin
                        underrun_det = 1'b1;
                        state_d      = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            last_q  <= 1'b0;
            idx_q   <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
            idx_q   <= idx_d;
            pcnt_q  <= pcnt_d;
        end
    end

endmodule

// File: rtl/rmii_tx_dibit_pick.sv
module rmii_tx_dibit_pick
    import rmii_tx_pkg::*;
(
    input  logic [BYTE_W-1:0]  byte_val,
    input  logic [IDX_W-1:0]   idx,
    output logic [DIBIT_W-1:0] dibit
);

    logic [DIBIT_W-1:0] lanes [DIBITS_PER_BYTE];

    for (genvar g = 0; g < DIBITS_PER_BYTE; g++) begin : g_lane
        assign lanes[g] = byte_val[g*DIBIT_W +: DIBIT_W];
    end

    assign dibit = lanes[idx];

endmodule

// File: rtl/rmii_tx_pin_reg.sv
module rmii_tx_pin_reg
    import rmii_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en_d,
    input  logic [DIBIT_W-1:0] dibit_d,
    input  logic               lpi_req,
    input  logic               urun_d,
    output logic               tx_en_q,
    output logic [DIBIT_W-1:0] txd_q,
    output logic               urun_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en_q <= 1'b0;
            txd_q   <= IDLE_NORMAL;
            urun_q  <= 1'b0;
        end else begin
            tx_en_q <= en_d;
            txd_q   <= en_d ? dibit_d : idle_code(lpi_req);
            urun_q  <= urun_d;
        end
    end

endmodule

// File: rtl/rmii_tx_dibit_ser.sv
module rmii_tx_dibit_ser
    import rmii_tx_pkg::*;
#(
    parameter int PREAMBLE_LEN = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              lpi_req,
    output logic              rmii_tx_en,
    output logic [1:0]        rmii_txd,
    output logic              underrun_pulse
);

    emit_t              emit;
    logic               urun_det;
    logic [DIBIT_W-1:0] dibit;

    rmii_tx_seq #(
        .PREAMBLE_LEN(PREAMBLE_LEN)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (s_valid),
        .in_data     (s_data),
        .in_last     (s_last),
        .lpi_req     (lpi_req),
        .line_busy   (rmii_tx_en),
        .in_ready    (s_ready),
        .emit        (emit),
        .underrun_det(urun_det)
    );

    rmii_tx_dibit_pick pick_i (
        .byte_val(emit.byte_val),
        .idx     (emit.idx),
        .dibit   (dibit)
    );

    rmii_tx_pin_reg pins_i (
        .clk    (clk),
        .rst    (rst),
        .en_d   (emit.en),
        .dibit_d(dibit),
        .lpi_req(lpi_req),
        .urun_d (urun_det),
        .tx_en_q(rmii_tx_en),
        .txd_q  (rmii_txd),
        .urun_q (underrun_pulse)
    );

endmodule

// File: rtl/rmii_tx_dibit_ser_chk.sv
module rmii_tx_dibit_ser_chk (
    input logic       clk,
    input logic       rst,
    input logic       s_valid,
    input logic       s_ready,
    input logic       lpi_req,
    input logic       rmii_tx_en,
    input logic [1:0] rmii_txd,
    input logic       underrun_pulse
);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R5: a byte is only taken while offered and while a frame is on the line
    a_r5_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (s_valid && rmii_tx_en));

    // R2: the enable rises together with the first preamble dibit (01)
    a_r2_start_dibit: assert property (@(posedge clk) disable iff (rst)
        $rose(rmii_tx_en) |-> rmii_txd == 2'b01);

    // R6 / R7: idle code follows the previous cycle's low-power request
    a_r7_idle_code: assert property (@(posedge clk) disable iff (rst)
        (seen && !rmii_tx_en) |-> rmii_txd == {1'b0, $past(lpi_req)});

    // R9: underrun is a single pulse on the last dibit of a cut frame
    a_r9_urun_on_line: assert property (@(posedge clk) disable iff (rst)
        underrun_pulse |-> rmii_tx_en);
    a_r9_urun_ends: assert property (@(posedge clk) disable iff (rst)
        underrun_pulse |=> (!underrun_pulse && !rmii_tx_en));

    // R10: no frame starts while low-power idle is requested
    a_r10_lpi_blocks: assert property (@(posedge clk) disable iff (rst)
        (!rmii_tx_en && lpi_req) |=> !rmii_tx_en);

endmodule

bind rmii_tx_dibit_ser rmii_tx_dibit_ser_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .s_valid       (s_valid),
    .s_ready       (s_ready),
    .lpi_req       (lpi_req),
    .rmii_tx_en    (rmii_tx_en),
    .rmii_txd      (rmii_txd),
    .underrun_pulse(underrun_pulse)
);

// File: tb/rmii_tx_dibit_ser_tb_top.sv
`timescale 1ns/1ps
module rmii_tx_dibit_ser_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic       lpi_req = 1'b0;
    logic       s_ready;
    logic       rmii_tx_en;
    logic [1:0] rmii_txd;
    logic       underrun_pulse;

    always #2.5 clk = ~clk;

    rmii_tx_dibit_ser dut_i (
        .clk           (clk),
        .rst           (rst),
        .s_valid       (s_valid),
        .s_data        (s_data),
        .s_last        (s_last),
        .s_ready       (s_ready),
        .lpi_req       (lpi_req),
        .rmii_tx_en    (rmii_tx_en),
        .rmii_txd      (rmii_txd),
        .underrun_pulse(underrun_pulse)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // capture of one frame
    logic [1:0] cap [0:1023];
    int cap_n, ready_cnt, first_ready, urun_cnt, urun_pos, idle_after;

    function automatic logic [7:0] vbyte(input int base, input int step, input int i);
        return 8'((base + i * step) & 255);
    endfunction

    task automatic run_frame(input int len, input int base, input int step,
                             input int stop_at, input bit lpi_mid);
        int  idx = 0;
        bit  took = 0;
        bit  started = 0;
        bit  done = 0;
        int  cyc = 0;
        cap_n = 0; ready_cnt = 0; first_ready = -1;
        urun_cnt = 0; urun_pos = -1; idle_after = -1;
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = vbyte(base, step, 0);
        s_last  = (len == 1);
        #1 took = s_ready;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (underrun_pulse) begin
                urun_cnt++;
                urun_pos = rmii_tx_en ? cap_n : -2;
            end
            if (rmii_tx_en) begin
                started = 1;
                cap[cap_n] = rmii_txd;
                cap_n++;
            end else if (started) begin
                done = 1;
                idle_after = int'(rmii_txd);
            end
            if (took) begin
                idx++;
                if (idx < len) begin
                    s_data = vbyte(base, step, idx);
                    s_last = (idx == len - 1);
                end else begin
                    s_valid = 1'b0;
                end
            end
            if (started && stop_at >= 0 && idx >= stop_at) s_valid = 1'b0;
            if (lpi_mid && cap_n == 40) lpi_req = 1'b1;
            #1 took = s_ready;
            if (took) begin
                ready_cnt++;
                if (first_ready < 0) first_ready = cap_n;
            end
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic judge(input int len, input int base, input int step,
                         input int stop_at, input int exp_dibits, input int exp_idle);
        int sent = (stop_at >= 0) ? stop_at : len;
        int bad_pre = 0;
        int bad_pay = 0;
        check(cap_n == exp_dibits, "R4", "enable length", cap_n, exp_dibits);
        for (int b = 0; b < 8; b++) begin
            logic [7:0] got = {cap[4*b+3], cap[4*b+2], cap[4*b+1], cap[4*b]};
            if (got != ((b < 7) ? 8'h55 : 8'hD5)) bad_pre++;
        end
        check(bad_pre == 0, "R2", "preamble/SFD byte errors", bad_pre, 0);
        for (int j = 0; j < sent; j++) begin
            int o = 32 + 4 * j;
            logic [7:0] got = {cap[o+3], cap[o+2], cap[o+1], cap[o]};
            if (got != vbyte(base, step, j)) bad_pay++;
        end
        check(bad_pay == 0, "R3", "payload byte errors", bad_pay, 0);
        check(ready_cnt == sent, "R5", "ready count", ready_cnt, sent);
        if (sent > 0)
            check(first_ready == 31, "R5", "first ready position", first_ready, 31);
        if (stop_at >= 0) begin
            check(urun_cnt == 1, "R9", "underrun pulses", urun_cnt, 1);
            check(urun_pos == cap_n - 1, "R9", "underrun position", urun_pos, cap_n - 1);
        end else begin
            check(urun_cnt == 0, "R9", "spurious underrun", urun_cnt, 0);
        end
        check(idle_after == exp_idle, (exp_idle == 1) ? "R8" : "R6",
              "first idle code", idle_after, exp_idle);
    endtask

    // len, base, step, stop (-1 none), expected enable cycles
    localparam int NVEC = 6;
    localparam int VEC [NVEC][5] = '{
        '{1, 8'hA5, 0,     -1, 36},
        '{4, 8'h00, 8'h11, -1, 48},
        '{6, 8'hFF, 8'hF3, -1, 56},
        '{3, 8'h3C, 1,      1, 36},
        '{5, 8'h10, 7,      0, 32},
        '{2, 8'hC3, 8'h5A, -1, 40}
    };

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rmii_tx_en == 0 && rmii_txd == 2'b00 && s_ready == 0 && underrun_pulse == 0,
              "R1", "outputs in reset", {rmii_tx_en, rmii_txd, s_ready, underrun_pulse}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(rmii_tx_en == 0 && rmii_txd == 2'b00, "R1", "outputs after reset",
              {rmii_tx_en, rmii_txd}, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
            judge(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0);
            repeat (3) @(negedge clk);
        end

        // R8: LPI request raised mid-frame, frame intact, 01 right after enable falls
        run_frame(5, 8'h81, 8'h13, -1, 1'b1);
        judge(5, 8'h81, 8'h13, -1, 52, 1);

        // R7 / R10: LPI held in idle, offered byte ignored
        begin
            int en_seen = 0;
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = 8'h77;
            s_last  = 1'b1;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (rmii_tx_en) en_seen++;
                if (s_ready) en_seen++;
            end
            check(en_seen == 0, "R10", "activity while LPI", en_seen, 0);
            check(rmii_txd == 2'b01, "R7", "LPI idle code", rmii_txd, 1);
            s_valid = 1'b0;
            lpi_req = 1'b0;
            repeat (2) @(negedge clk);
            check(rmii_txd == 2'b00 && rmii_tx_en == 0, "R6", "normal idle code", rmii_txd, 0);
        end

        // R4: a normal frame after leaving LPI still works
        run_frame(2, 8'h5A, 8'h01, -1, 1'b0);
        judge(2, 8'h5A, 8'h01, -1, 40, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule